// File: doc/BRIEF.md
# Pedestal-Corrected Zero-Suppression Unit

This unit receives a stream of raw 12-bit front-end samples. Each time sample is delivered as a pass over 128 channels in transmission order. For every sample the unit looks up the channel's stored baseline and noise width, subtracts the baseline, and compares the signed result with a noise-scaled threshold. The threshold multiplier is a 6.6 fixed-point number. It comes either from a configuration word or from a built-in default. The result is a per-sample output stream and, on the last time sample of a frame, one verdict per channel. The verdict says whether the channel is kept, and it carries the channel's largest corrected sample together with the sample index where that value occurred.

A 128-entry pair of 12-bit tables holds the baseline and noise values. Calibration software reads and writes these tables over a simple register port. Bit 31 of the address picks the table. The unit also renames each channel from its transmission order to its physical strip number. Control bits can force every channel to be kept, bypass the baseline subtraction, or suppress the per-sample stream so that only the peak value and its position leave the block.

Top module: `zs_unit`

## Requirements
- R1: One clock after an input sample with `in_valid`=1 (and peak mode off), `smp_valid`=1 and `smp_value` = `in_data` − baseline[`in_chan`], a 13-bit signed value. `smp_index` equals `in_smp`.
- R2: When `cfg_prm` bit 2 is 1, the baseline is taken as 0, so `smp_value` equals `in_data` zero-extended.
- R3: When `cfg_prm` bit 4 is 1, the multiplier M is `cfg_thr[13:8]`.`cfg_thr[7:2]` (6 integer and 6 fraction bits). `smp_over` is 1 exactly when value > 0 and value·64 > M·noise[`in_chan`] (strictly greater). `cfg_thr` bits 15:14 and 1:0 have no effect.
- R4: When `cfg_prm` bit 4 is 0, M is fixed at 3.0 (raw 192), and `cfg_thr` is ignored.
- R5: A verdict (`ver_valid`=1) appears one clock after each input with `in_last`=1, and at no other time. `ver_keep` is 1 if any sample of that channel in the frame (`in_smp` 0 through the last) was over threshold.
- R6: When `cfg_prm` bit 3 is 1, `ver_keep` is 1 for every channel.
- R7: When `cfg_prm` bit 1 is 1, `smp_valid` stays 0, and only verdicts are produced.
- R8: `ver_peak` is the largest signed corrected value of the channel in the frame, and `ver_peak_idx` is the sample index where it occurred. On a tie the earliest index wins. An input with `in_smp`=0 starts a new frame for its channel.
- R9: `smp_chan` and `ver_chan` give the physical number p = 32·(n mod 4) + 8·⌊n/4⌋ − 31·⌊n/16⌋, where n is `in_chan`.
- R10: A write with `cal_we`=1 stores `cal_wdata` in the noise table if `cal_addr[31]`=1 and in the baseline table if it is 0, at channel `cal_addr[6:0]`. Address bits 30:8 are ignored. A write with `cal_addr[7]`=1 changes nothing.
- R11: `cal_rdata` returns the addressed entry one clock after `cal_re`=1. It returns 0 when `cal_addr[7]`=1. Both tables read 0 after reset.
- R12: `cfg_prm` bits 15:5 and bit 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr | input | 16 | Threshold multiplier word (bits 13:2 used) |
| cfg_prm | input | 16 | Mode bits: 1 peak-only, 2 no baseline, 3 keep all, 4 use cfg_thr |
| in_valid | input | 1 | Sample present |
| in_chan | input | 7 | Channel in transmission order |
| in_smp | input | 5 | Time-sample index within the frame |
| in_last | input | 1 | Last time sample of the frame |
| in_data | input | 12 | Raw sample |
| cal_we | input | 1 | Calibration table write strobe |
| cal_re | input | 1 | Calibration table read strobe |
| cal_addr | input | 32 | Table select (31), range bit (7), channel (6:0) |
| cal_wdata | input | 12 | Write value |
| cal_rdata | output | 12 | Read value |
| smp_valid | output | 1 | Per-sample result present |
| smp_chan | output | 7 | Physical channel |
| smp_index | output | 5 | Sample index |
| smp_value | output | 13 | Corrected signed value |
| smp_over | output | 1 | Sample above threshold |
| ver_valid | output | 1 | Channel verdict present |
| ver_chan | output | 7 | Physical channel |
| ver_keep | output | 1 | Channel kept |
| ver_peak | output | 13 | Largest corrected value |
| ver_peak_idx | output | 5 | Sample index of the largest value |

## Verification
The per-sample result and the verdict both come from the same single output register, so they are due one clock after the input that caused them. A table read is due one clock after its strobe. The bench drives each input on a falling edge, computes that input's expected outputs at once from its own copy of the tables and a per-channel peak model, and compares them at the next falling edge, just before the next input is driven. Table reads are compared on the falling edge after the strobe.

// File: rtl/zs_pkg.sv
package zs_pkg;
    localparam int unsigned DATA_W = 12;
    localparam int unsigned COR_W  = DATA_W + 1;
    localparam int unsigned NCH    = 128;
    localparam int unsigned CH_W   = $clog2(NCH);
    localparam int unsigned SIDX_W = 5;
    localparam int unsigned FRAC_W = 6;
    localparam int unsigned MULT_W = 2 * FRAC_W;
    localparam int unsigned PROD_W = MULT_W + DATA_W;
    localparam int unsigned THR_LSB = 2;

    localparam int unsigned PRM_PEAK   = 1;
    localparam int unsigned PRM_NOPED  = 2;
    localparam int unsigned PRM_FORCE  = 3;
    localparam int unsigned PRM_THRSEL = 4;

    typedef logic signed [COR_W-1:0] cor_t;

    typedef struct packed {
        logic              over;
        cor_t              peak;
        logic [SIDX_W-1:0] pidx;
    } track_t;

    typedef struct packed {
        logic              smp_valid;
        logic [CH_W-1:0]   smp_chan;
        logic [SIDX_W-1:0] smp_index;
        cor_t              smp_value;
        logic              smp_over;
        logic              ver_valid;
        logic [CH_W-1:0]   ver_chan;
        logic              ver_keep;
        cor_t              ver_peak;
        logic [SIDX_W-1:0] ver_peak_idx;
    } zs_out_t;

    // Transmission order to physical strip number.
    function automatic logic [CH_W-1:0] tx_to_phys(input logic [CH_W-1:0] n);
        int k;
        int v;
        k = int'(n);
        v = 32 * (k % 4) + 8 * (k / 4) - 31 * (k / 16);
        return CH_W'(v);
    endfunction
endpackage

// File: rtl/zs_calmem.sv
module zs_calmem
    import zs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [31:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CH_W-1:0]   lk_chan,
    output logic [DATA_W-1:0] lk_ped,
    output logic [DATA_W-1:0] lk_sig
);
    localparam int unsigned SEL_BIT   = 31;
    localparam int unsigned RANGE_BIT = CH_W;

    logic [DATA_W-1:0] ped_q [NCH];
    logic [DATA_W-1:0] sig_q [NCH];
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              in_range;
    logic [CH_W-1:0]   slot;
    logic              unused_addr;

    assign in_range    = ~addr[RANGE_BIT];
    assign slot        = addr[CH_W-1:0];
    assign unused_addr = ^addr[SEL_BIT-1:RANGE_BIT+1];
    assign lk_ped      = ped_q[lk_chan];
    assign lk_sig      = sig_q[lk_chan];
    assign rdata       = rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            if (!in_range)          rdata_d = '0;
            else if (addr[SEL_BIT]) rdata_d = sig_q[slot];
            else                    rdata_d = ped_q[slot];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                ped_q[i] <= '0;
                sig_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (we && in_range) begin
                if (addr[SEL_BIT]) sig_q[slot] <= wdata;
                else               ped_q[slot] <= wdata;
            end
            rdata_q <= rdata_d;
        end
    end
endmodule

// File: rtl/zs_thresh.sv
module zs_thresh
    import zs_pkg::*;
(
    input  cor_t              corr,
    input  logic [DATA_W-1:0] sigma,
    input  logic [MULT_W-1:0] mult,
    output logic              over
);
    logic [PROD_W-1:0] limit;
    logic [PROD_W-1:0] scaled;

    assign limit  = PROD_W'(mult) * PROD_W'(sigma);
    assign scaled = PROD_W'(corr[COR_W-2:0]) << FRAC_W;
    assign over   = ~corr[COR_W-1] & (scaled > limit);
endmodule

// File: rtl/zs_track.sv
module zs_track
    import zs_pkg::*;
(
    input  logic              clk,
    input  logic              valid,
    input  logic [CH_W-1:0]   chan,
    input  logic [SIDX_W-1:0] sidx,
    input  cor_t              corr,
    input  logic              over,
    output track_t            upd
);
    track_t mem_q [NCH];
    track_t old;

    always_comb begin
        old = mem_q[chan];
        if (sidx == '0) begin
            upd.over = over;
            upd.peak = corr;
            upd.pidx = '0;
        end else begin
            upd.over = old.over | over;
            if ($signed(corr) > $signed(old.peak)) begin
                upd.peak = corr;
                upd.pidx = sidx;
            end else begin
                upd.peak = old.peak;
                upd.pidx = old.pidx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (valid) mem_q[chan] <= upd;
    end
endmodule

// File: rtl/zs_unit.sv
module zs_unit
    import zs_pkg::*;
#(
    parameter logic [MULT_W-1:0] AUTO_MULT = MULT_W'(3 << FRAC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cfg_thr,
    input  logic [15:0]       cfg_prm,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [SIDX_W-1:0] in_smp,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cal_we,
    input  logic              cal_re,
    input  logic [31:0]       cal_addr,
    input  logic [DATA_W-1:0] cal_wdata,
    output logic [DATA_W-1:0] cal_rdata,
    output logic              smp_valid,
    output logic [CH_W-1:0]   smp_chan,
    output logic [SIDX_W-1:0] smp_index,
    output logic [COR_W-1:0]  smp_value,
    output logic              smp_over,
    output logic              ver_valid,
    output logic [CH_W-1:0]   ver_chan,
    output logic              ver_keep,
    output logic [COR_W-1:0]  ver_peak,
    output logic [SIDX_W-1:0] ver_peak_idx
);
    logic [DATA_W-1:0] lk_ped, lk_sig, ped_eff;
    logic [MULT_W-1:0] mult;
    cor_t              corr;
    logic              over;
    track_t            upd;
    zs_out_t           out_d, out_q;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg_thr[15:THR_LSB+MULT_W], cfg_thr[THR_LSB-1:0],
                          cfg_prm[15:PRM_THRSEL+1], cfg_prm[0]};

    zs_calmem u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cal_we),
        .re      (cal_re),
        .addr    (cal_addr),
        .wdata   (cal_wdata),
        .rdata   (cal_rdata),
        .lk_chan (in_chan),
        .lk_ped  (lk_ped),
        .lk_sig  (lk_sig)
    );

    always_comb begin
        ped_eff = cfg_prm[PRM_NOPED] ? '0 : lk_ped;
        corr    = $signed({1'b0, in_data}) - $signed({1'b0, ped_eff});
        mult    = cfg_prm[PRM_THRSEL] ? cfg_thr[THR_LSB +: MULT_W] : AUTO_MULT;
    end

    zs_thresh u_thr (
        .corr  (corr),
        .sigma (lk_sig),
        .mult  (mult),
        .over  (over)
    );

    zs_track u_trk (
        .clk   (clk),
        .valid (in_valid),
        .chan  (in_chan),
        .sidx  (in_smp),
        .corr  (corr),
        .over  (over),
        .upd   (upd)
    );

    always_comb begin
        out_d              = out_q;
        out_d.smp_valid    = in_valid & ~cfg_prm[PRM_PEAK];
        out_d.smp_chan     = tx_to_phys(in_chan);
        out_d.smp_index    = in_smp;
        out_d.smp_value    = corr;
        out_d.smp_over     = over;
        out_d.ver_valid    = in_valid & in_last;
        out_d.ver_chan     = tx_to_phys(in_chan);
        out_d.ver_keep     = cfg_prm[PRM_FORCE] | upd.over;
        out_d.ver_peak     = upd.peak;
        out_d.ver_peak_idx = upd.pidx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign smp_valid    = out_q.smp_valid;
    assign smp_chan     = out_q.smp_chan;
    assign smp_index    = out_q.smp_index;
    assign smp_value    = out_q.smp_value;
    assign smp_over     = out_q.smp_over;
    assign ver_valid    = out_q.ver_valid;
    assign ver_chan     = out_q.ver_chan;
    assign ver_keep     = out_q.ver_keep;
    assign ver_peak     = out_q.ver_peak;
    assign ver_peak_idx = out_q.ver_peak_idx;
endmodule

// File: rtl/zs_unit_chk.sv
module zs_unit_chk
    import zs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cfg_prm,
    input logic              in_valid,
    input logic              in_last,
    input logic [DATA_W-1:0] in_data,
    input logic              cal_re,
    input logic [31:0]       cal_addr,
    input logic [DATA_W-1:0] cal_rdata,
    input logic              smp_valid,
    input logic [CH_W-1:0]   smp_chan,
    input logic [COR_W-1:0]  smp_value,
    input logic              smp_over,
    input logic              ver_valid,
    input logic [CH_W-1:0]   ver_chan,
    input logic              ver_keep
);
    // R5: verdicts only follow a last-sample input
    a_r5_verdict_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        ver_valid |-> $past(in_valid && in_last));

    // R5: an over-threshold last sample means the channel is kept
    a_r5_over_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_over && ver_valid) |-> ver_keep);

    // R7: no per-sample output in peak-only mode
    a_r7_peak_silent: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ($past(in_valid) && !$past(cfg_prm[PRM_PEAK])));

    // R6: keep-all forces the verdict
    a_r6_force_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ver_valid && $past(cfg_prm[PRM_FORCE])) |-> ver_keep);

    // R2: baseline bypass passes the raw sample
    a_r2_noped_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && $past(cfg_prm[PRM_NOPED])) |-> (smp_value == {1'b0, $past(in_data)}));

    // R11: out-of-range read returns zero
    a_r11_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cal_re) && $past(cal_addr[CH_W])) |-> (cal_rdata == '0));

    // R9: both streams name the same channel for the same input
    a_r9_same_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ver_valid) |-> (smp_chan == ver_chan));
endmodule

bind zs_unit zs_unit_chk u_chk (.*);

// File: tb/tb_zs_unit.sv
`timescale 1ns/1ps
module tb_zs_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_thr = '0, cfg_prm = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [6:0]  in_chan = '0;
    logic [4:0]  in_smp = '0;
    logic [11:0] in_data = '0;
    logic        cal_we = 1'b0, cal_re = 1'b0;
    logic [31:0] cal_addr = '0;
    logic [11:0] cal_wdata = '0;
    logic [11:0] cal_rdata;
    logic        smp_valid, smp_over, ver_valid, ver_keep;
    logic [6:0]  smp_chan, ver_chan;
    logic [4:0]  smp_index, ver_peak_idx;
    logic [12:0] smp_value, ver_peak;

    always #2.5 clk = ~clk;

    zs_unit dut (.*);

    int checks = 0, errors = 0;
    int ped [128], sig [128];
    int m_over [128], m_peak [128], m_idx [128];
    // expectations for the input driven on the previous falling edge
    bit e_sv, e_vv, e_over, e_keep, e_peakmode, e_noped, e_thrsel, e_force;
    int e_sch, e_val, e_sidx, e_pk, e_pidx, e_vch;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int phys(input int n);
        return 32 * (n % 4) + 8 * (n / 4) - 31 * (n / 16);
    endfunction

    function automatic bit over_model(input int corr, input int s, input int m);
        return (corr > 0) && (corr * 64 > m * s);
    endfunction

    task automatic check_outputs();
        chk(e_peakmode ? "R7" : "R1", int'(smp_valid), int'(e_sv));
        if (e_sv) begin
            chk("R9", int'(smp_chan), e_sch);
            chk("R1", int'(smp_index), e_sidx);
            chk(e_noped ? "R2" : "R1", int'($signed(smp_value)), e_val);
            chk(e_thrsel ? "R3" : "R4", int'(smp_over), int'(e_over));
        end
        chk("R5", int'(ver_valid), int'(e_vv));
        if (e_vv) begin
            chk(e_force ? "R6" : "R5", int'(ver_keep), int'(e_keep));
            chk("R8", int'($signed(ver_peak)), e_pk);
            chk("R8", int'(ver_peak_idx), e_pidx);
            chk("R9", int'(ver_chan), e_vch);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_outputs();
        in_valid = 1'b0; in_last = 1'b0; cal_we = 1'b0; cal_re = 1'b0;
        e_sv = 1'b0; e_vv = 1'b0;
    endtask

    task automatic cal_write(input logic [31:0] a, input int d);
        tick();
        cal_we = 1'b1; cal_addr = a; cal_wdata = 12'(d);
        if (!a[7]) begin
            if (a[31]) sig[a[6:0]] = d;
            else       ped[a[6:0]] = d;
        end
    endtask

    task automatic cal_read(input logic [31:0] a, input int exp, input string req);
        tick();
        cal_re = 1'b1; cal_addr = a;
        tick();
        chk(req, int'(cal_rdata), exp);
    endtask

    task automatic send(input int n, input int s, input bit last, input int d);
        int corr, m;
        bit ov;
        tick();
        in_valid = 1'b1; in_chan = 7'(n); in_smp = 5'(s); in_last = last; in_data = 12'(d);
        e_peakmode = cfg_prm[1]; e_noped = cfg_prm[2];
        e_force = cfg_prm[3]; e_thrsel = cfg_prm[4];
        m = e_thrsel ? int'(cfg_thr[13:2]) : 192;
        corr = d - (e_noped ? 0 : ped[n]);
        ov = over_model(corr, sig[n], m);
        if (s == 0) begin
            m_over[n] = ov; m_peak[n] = corr; m_idx[n] = 0;
        end else begin
            m_over[n] = m_over[n] | int'(ov);
            if (corr > m_peak[n]) begin m_peak[n] = corr; m_idx[n] = s; end
        end
        e_sv = !e_peakmode; e_sch = phys(n); e_sidx = s; e_val = corr; e_over = ov;
        e_vv = last; e_keep = e_force || (m_over[n] != 0);
        e_pk = m_peak[n]; e_pidx = m_idx[n]; e_vch = phys(n);
    endtask

    // pattern 0: random near baseline, 1: constant per channel (ties), 2: threshold boundary on 5/6
    task automatic run_frame(input logic [15:0] thr, input logic [15:0] prm,
                             input int ns, input int pat);
        tick();
        cfg_thr = thr; cfg_prm = prm;
        for (int s = 0; s < ns; s++) begin
            for (int n = 0; n < 128; n++) begin
                int d;
                d = ped[n] + int'($urandom_range(0, 400)) - 100;
                if (pat == 1) d = ped[n] + (n % 7) * 10;
                if (pat == 2 && n == 5) d = (s == ns - 1) ? 165 : 164;
                if (pat == 2 && n == 6) d = 164;
                if (d < 0) d = 0;
                if (d > 4095) d = 4095;
                send(n, s, s == ns - 1, d);
            end
        end
        tick();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run incomplete, got 0 expected 1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7301));
        for (int i = 0; i < 128; i++) begin
            ped[i] = 0; sig[i] = 0; m_over[i] = 0; m_peak[i] = 0; m_idx[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(smp_valid), 0);
        chk("R5", int'(ver_valid), 0);
        chk("R11", int'(cal_rdata), 0);
        cal_read(32'h0000_0003, 0, "R11");
        cal_read(32'h8000_0010, 0, "R11");

        // R10: load both tables with reserved address bits scrambled
        for (int i = 0; i < 128; i++) begin
            cal_write((32'(i) | ($urandom() & 32'h7FFF_FF00)), int'($urandom_range(0, 2047)));
            cal_write((32'h8000_0000 | 32'(i) | ($urandom() & 32'h7FFF_FF00)),
                      int'($urandom_range(0, 40)));
        end
        for (int k = 0; k < 12; k++) begin
            int c;
            c = int'($urandom_range(0, 127));
            cal_read(32'(c), ped[c], "R10");
            cal_read(32'h8000_0000 | 32'(c), sig[c], "R10");
        end
        // R10: range bit set, write ignored
        cal_write(32'h0000_0085, 12'hABC);
        cal_read(32'h0000_0005, ped[5], "R10");
        cal_read(32'h8000_0085, 0, "R11");

        run_frame(16'h0000, 16'h0000, 4, 0);                           // R4 auto
        run_frame({2'b11, 6'd2, 6'd32, 2'b11}, 16'h0010, 3, 0);        // R3 2.5
        run_frame(16'h0100, 16'h0014, 3, 0);                           // R2
        run_frame(16'h0000, 16'h0008, 5, 0);                           // R6
        run_frame(16'h0000, 16'h0002, 6, 0);                           // R7
        run_frame({2'b00, 6'd1, 6'd48, 2'b00}, 16'hFFF3, 4, 0);        // R12 reserved set
        run_frame(16'h0000, 16'h0002, 4, 1);                           // R8 ties
        // R3 boundary: baseline 100, noise 64, multiplier 1.0 -> over only above 164
        cal_write(32'h0000_0005, 100); cal_write(32'h8000_0005, 64);
        cal_write(32'h0000_0006, 100); cal_write(32'h8000_0006, 64);
        run_frame(16'h0100, 16'h0010, 3, 2);
        for (int f = 0; f < 4; f++)
            run_frame(16'($urandom()), 16'($urandom_range(0, 31)), int'($urandom_range(2, 6)), 0);
        finish_run();
    end
endmodule